// File: doc/BRIEF.md
# Per-line PLL lock qualifier

This block decides, once per video line, whether a line-locked PLL has settled. The phase detector hands it one signed phase-error sample per line, marked by a valid strobe. The block takes the magnitude of that sample and compares it with a programmable tolerance. It then counts consecutive in-tolerance lines against a programmable threshold. One tolerance step corresponds to about 200 ps of phase error.

When more than the threshold number of consecutive lines are in tolerance, the block raises a lock flag. A single out-of-tolerance line drops the flag again. A registered time-constant select follows the flag, so the loop filter runs with its lock constant while locked and with its slow constant otherwise.

The tolerance and the threshold are held in internal registers. Both are loaded together by a write strobe.

Top module: `line_lock_qual`

## Requirements
- R1: After reset, `locked` and `tc_sel` are 0, the tolerance register holds 0x20 and the line-threshold register holds 0x30.
- R2: A cycle with `cfg_wr` high loads `cfg_tol` and `cfg_lines` into the tolerance and threshold registers, and they are used from the next line onward.
- R3: A line is good only when the absolute value of the two's-complement `err_phase` is strictly less than the tolerance. An error whose magnitude equals the tolerance is bad, and negative errors are judged by magnitude.
- R4: On a valid line, `locked` becomes 1 at the clock edge that samples it, once the count of consecutive good lines, this one included, is greater than the threshold. With threshold N, the (N+1)th consecutive good line sets it and the Nth does not.
- R5: A single valid bad line clears `locked` at the edge that samples it and restarts the good-line count from zero.
- R6: Cycles with `err_valid` low change neither the count nor `locked`, whatever `err_phase` holds.
- R7: The good-line counter is one bit wider than the threshold and saturates at its all-ones value instead of wrapping, so lock holds through any run of good lines.
- R8: `tc_sel` is registered, is 1 (lock constant) while locked and 0 (slow constant) otherwise, and changes in the same cycle as `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for both configuration registers |
| cfg_tol | input | 8 | New tolerance value |
| cfg_lines | input | 8 | New line threshold |
| err_valid | input | 1 | One-cycle strobe, one per line |
| err_phase | input | 12 | Signed phase error of the line |
| locked | output | 1 | Lock status |
| tc_sel | output | 1 | Loop time constant: 1 lock, 0 slow |

## Verification
The assertions assume that `err_phase` is meaningful only in cycles where `err_valid` is high. They also assume that a configuration write and a line strobe never arrive in the same cycle, so every line is judged against settled registers. The stimulus keeps to both rules. It drives configuration writes in cycles of their own, and it scrambles `err_phase` during idle cycles so that the idle-cycle rule is actually exercised. Random errors are drawn within about twice the tolerance, which keeps good and bad lines both frequent. Directed runs cover the exact tolerance boundary, the most negative error, the threshold edge and counter saturation.

// File: rtl/line_lock_qual.sv
module line_lock_qual #(
  parameter int ERR_W = 12,
  parameter int TOL_W = 8,
  parameter int CNT_W = 8,
  parameter logic [TOL_W-1:0] TOL_RST = 8'h20,
  parameter logic [CNT_W-1:0] LINES_RST = 8'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [TOL_W-1:0] cfg_tol,
  input  logic [CNT_W-1:0] cfg_lines,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_phase,
  output logic             locked,
  output logic             tc_sel
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [TOL_W-1:0] tol_q;
  logic [CNT_W-1:0] lines_q;
  logic [CW-1:0]    cnt_q;
  logic [ERR_W-1:0] mag;
  logic [CW-1:0]    cnt_inc;
  logic             good, lock_nxt;

  assign mag      = err_phase[ERR_W-1] ? (~err_phase + 1'b1) : err_phase;
  assign good     = mag < ERR_W'(tol_q);
  assign cnt_inc  = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
  assign lock_nxt = good && (cnt_inc > CW'(lines_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tol_q   <= TOL_RST;
      lines_q <= LINES_RST;
    end else if (cfg_wr) begin
      tol_q   <= cfg_tol;
      lines_q <= cfg_lines;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      locked <= 1'b0;
      tc_sel <= 1'b0;
    end else if (err_valid) begin
      cnt_q  <= good ? cnt_inc : '0;
      locked <= lock_nxt;
      tc_sel <= lock_nxt;
    end
  end
endmodule

// File: rtl/line_lock_qual_chk.sv
module line_lock_qual_chk #(
  parameter int ERR_W = 12,
  parameter int TOL_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic [ERR_W-1:0] err_phase,
  input logic [TOL_W-1:0] tol_q,
  input logic [CNT_W:0]   cnt_q,
  input logic             locked,
  input logic             tc_sel
);
  logic signed [ERR_W:0] e_ext;
  logic [ERR_W:0]        e_abs;
  logic                  in_tol;

  assign e_ext  = {err_phase[ERR_W-1], err_phase};
  assign e_abs  = (e_ext < 0) ? -e_ext : e_ext;
  assign in_tol = e_abs < (ERR_W+1)'(tol_q);

  // R8
  tc_follows_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_sel == locked);

  // R5
  bad_line_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !in_tol |=> !locked && cnt_q == '0);

  // R6
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(locked) && $stable(cnt_q));

  // R7
  cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && in_tol && (&cnt_q) |=> &cnt_q);

  // R4
  lock_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(err_valid) && $past(in_tol));
endmodule

bind line_lock_qual line_lock_qual_chk #(.ERR_W(ERR_W), .TOL_W(TOL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_phase(err_phase),
  .tol_q(tol_q), .cnt_q(cnt_q), .locked(locked), .tc_sel(tc_sel));

// File: tb/line_lock_qual_test.sv
module line_lock_qual_test;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, cfg_wr = 0, err_valid = 0;
  logic [7:0] cfg_tol = 0, cfg_lines = 0;
  logic [11:0] err_phase = 0;
  logic locked, tc_sel;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0, m_tol = 32, m_lines = 48;
  bit m_lk = 0;

  always #(PER/2) clk = ~clk;

  line_lock_qual uut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tol(cfg_tol),
    .cfg_lines(cfg_lines), .err_valid(err_valid), .err_phase(err_phase),
    .locked(locked), .tc_sel(tc_sel));

  function automatic bit is_good(int e, int tol);
    int m = (e < 0) ? -e : e;
    return m < tol;
  endfunction

  task automatic check(string tag, bit exp);
    n_chk++;
    if (locked !== exp || tc_sel !== exp) begin
      n_bad++;
      $display("FAIL %s locked=%b tc_sel=%b expected %b", tag, locked, tc_sel, exp);
    end
  endtask

  task automatic line(string tag, bit v, int e);
    err_valid = v;
    err_phase = 12'(e);
    @(posedge clk);
    if (v) begin
      if (is_good(e, m_tol)) begin
        m_cnt = (m_cnt < 511) ? m_cnt + 1 : 511;
        m_lk = m_cnt > m_lines;
      end else begin
        m_cnt = 0;
        m_lk = 0;
      end
    end
    @(negedge clk);
    err_valid = 0;
    check(tag, m_lk);
  endtask

  task automatic cfg(int t, int l);
    cfg_wr = 1; cfg_tol = 8'(t); cfg_lines = 8'(l);
    @(posedge clk);
    m_tol = t; m_lines = l;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    #(PER*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    #(PER*3) @(negedge clk);
    rst_n = 1;
    check("R1 reset", 0);
    // R1: default threshold 0x30, default tolerance 0x20
    for (int i = 0; i < 48; i++) line("R1 default count", 1, 31);
    check("R1 not yet at 48 lines", 0);
    line("R4 lock on 49th line", 1, -31);
    check("R4 locked", 1);
    // R6: idle cycles with wild errors
    for (int i = 0; i < 5; i++) line("R6 idle ignored", 0, 2047);
    // R3: magnitude equal to tolerance is bad
    line("R3 equal tol is bad", 1, 32);
    line("R3 good restarts", 1, 0);
    line("R3 negative equal tol bad", 1, -32);
    line("R3 most negative bad", 1, -2048);
    // R2: new threshold and tolerance
    cfg(5, 3);
    line("R2 tol 5 good", 1, 4);
    line("R2", 1, -4);
    line("R2", 1, 4);
    check("R2 three lines not enough", 0);
    line("R2 fourth line locks", 1, 4);
    line("R5 bad line clears", 1, 5);
    check("R5 cleared", 0);
    for (int i = 0; i < 3; i++) line("R5 count restarted", 1, 1);
    check("R5 still unlocked after 3", 0);
    line("R8 tc with lock", 1, 1);
    // R7: long run past counter max, threshold 255
    cfg(100, 255);
    for (int i = 0; i < 600; i++) line("R7 saturating run", 1, 10);
    check("R7 lock held after 600", 1);
    line("R5 drop after long run", 1, 100);
    // random mix
    cfg(32, 6);
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(128)) - 64;
      bit v = ($urandom_range(9) < 7);
      if ($urandom_range(15) == 0 && !v) cfg(int'($urandom_range(1, 60)), int'($urandom_range(12)));
      else line("R4 R5 R6 random", v, ($urandom_range(3) == 0) ? r : r / 4);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule